// File: doc/BRIEF.md
# Expansion Card EEPROM Mailbox

This block sits on a simple 16-bit register bus and gives a host processor two things: a presence map for up to three small expansion cards, and a way to read 16-bit words out of each card's identification EEPROM. The EEPROM contents are held inside the block as fixed per-card byte arrays, and a presence mask parameter marks which cards are fitted.

To read from a card, the host first writes a sparse 16-bit select code that names the card. It then writes a two-word EEPROM command to the mailbox. The first word carries the READ opcode together with a 6-bit offset, and the second word is zero. The next mailbox read returns the two bytes starting at that offset, and the read disarms the mailbox. A status register always returns a fixed value. Reads are combinational and are valid in the cycle of the read strobe. All state changes on the rising clock edge.

The bus uses a 2-bit register index. Index 0 is presence on read and select on write. Index 1 is status. Index 2 is the mailbox. Index 3 is reserved and reads 0x0000.

Top module: `mbx_eeprom_mailbox`

## Requirements
- R1: A read of index 0 returns 0xFFFF with bit c cleared for every fitted card c (active low). The default presence mask fits cards 0 and 2 and leaves card 1 empty, so the default read value is 0xFFFA.
- R2: A write to index 0 stores the full 16-bit word as the select code. Code 0x3500 picks card 2, 0x1D00 picks card 1 and 0x1700 picks card 0. Every other code picks no card.
- R3: Mailbox writes fill a two-entry command buffer in order. The mailbox is armed only after the second write, and the write pointer then returns to the first entry. A single write does not arm it.
- R4: A mailbox read while armed, with a fitted card selected, returns byte[off] in bits 15:8 and byte[(off+1) mod 64] in bits 7:0, where off is bits 5:0 of the first command word. Bits 15:6 of that word are ignored. Byte a of card c is (7*a + 85*c + 19) mod 256.
- R5: A mailbox read while armed disarms the mailbox at that clock edge, so the following read returns 0xFFFF.
- R6: A mailbox read while the mailbox is not armed returns 0xFFFF.
- R7: A mailbox read while armed, with no card selected or with an empty card selected, returns 0xFFFF and still disarms the mailbox.
- R8: A read of index 1 returns 0x0004, and writes to index 1 change no later read value. Reads of index 3 return 0x0000.
- R9: A synchronous active-high reset clears the select code, the write pointer, the armed flag and both command words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle |

## Verification
A wrong write pointer or armed flag shows up at the first mailbox read after the faulty state. The result is either 0xFFFF where a data word was due, or data where 0xFFFF was due. The check therefore fails within one command sequence. A corrupted select code or offset does not stall anything. It gives a data word from the wrong card or from the wrong address, so each armed read compares the full word against the content formula. Random sequences that interleave select writes, partial commands and repeated reads bring these states out at the ports within a few accesses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int DATA_W  = 16;
    localparam int N_CARDS = 3;
    localparam int OFF_W   = 6;

    typedef enum logic [1:0] {
        REG_PRESENCE = 2'd0,
        REG_STATUS   = 2'd1,
        REG_MAILBOX  = 2'd2,
        REG_RESERVED = 2'd3
    } reg_idx_e;

    localparam logic [DATA_W-1:0] STATUS_WORD = 16'h0004;
    localparam logic [DATA_W-1:0] EMPTY_WORD  = 16'hFFFF;

    typedef struct packed {
        logic [DATA_W-1:0] sel;
        logic              ptr;
        logic              armed;
        logic [DATA_W-1:0] cmd0;
        logic [DATA_W-1:0] cmd1;
    } mbx_regs_t;

    function automatic logic [7:0] card_byte(input int card, input int addr);
        int v;
        v = addr * 7 + card * 85 + 19;
        return v[7:0];
    endfunction

endpackage

// File: rtl/mbx_sel_decode.sv
module mbx_sel_decode
    import mbx_pkg::*;
#(
    parameter int                 NC    = N_CARDS,
    parameter logic [NC*16-1:0]   CODES = {16'h3500, 16'h1D00, 16'h1700}
) (
    input  logic [15:0]   sel_code,
    output logic [NC-1:0] card_onehot
);
    for (genvar c = 0; c < NC; c++) begin : g_match
        assign card_onehot[c] = (sel_code == CODES[c*16 +: 16]);
    end
endmodule

// File: rtl/mbx_card_rom.sv
module mbx_card_rom
    import mbx_pkg::*;
#(
    parameter int          NC      = N_CARDS,
    parameter int          OW      = OFF_W,
    parameter logic [NC-1:0] PRESENT = 3'b101
) (
    input  logic [NC-1:0] card_onehot,
    input  logic [OW-1:0] offset,
    output logic [NC-1:0] present_n,
    output logic          hit,
    output logic [15:0]   word
);
    localparam int DEPTH = 1 << OW;

    logic [OW-1:0]  off_next;
    logic [15:0]    card_word [NC];
    logic [NC-1:0]  card_hit;

    assign off_next  = offset + OW'(1);
    assign present_n = ~PRESENT;

    for (genvar c = 0; c < NC; c++) begin : g_card
        logic [7:0] mem [DEPTH];
        always_comb begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] = card_byte(c, i);
            end
        end
        assign card_word[c] = {mem[offset], mem[off_next]};
        assign card_hit[c]  = card_onehot[c] & PRESENT[c];
    end

    always_comb begin
        word = '0;
        for (int c = 0; c < NC; c++) begin
            if (card_hit[c]) word = word | card_word[c];
        end
    end

    assign hit = |card_hit;
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_wr,
    input  logic              mbx_wr,
    input  logic              mbx_rd,
    input  logic [DATA_W-1:0] wdata,
    output mbx_regs_t         regs_q
);
    mbx_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (sel_wr) begin
            regs_d.sel = wdata;
        end
        if (mbx_wr) begin
            if (regs_q.ptr) begin
                regs_d.cmd1  = wdata;
                regs_d.ptr   = 1'b0;
                regs_d.armed = 1'b1;
            end else begin
                regs_d.cmd0 = wdata;
                regs_d.ptr  = 1'b1;
            end
        end
        if (mbx_rd) begin
            regs_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/mbx_eeprom_mailbox.sv
module mbx_eeprom_mailbox
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata
);
    mbx_regs_t            regs_q;
    logic                 sel_wr, mbx_wr, mbx_rd;
    logic [N_CARDS-1:0]   card_onehot;
    logic [N_CARDS-1:0]   present_n;
    logic                 card_hit;
    logic [15:0]          card_word;
    reg_idx_e             idx;

    assign idx    = reg_idx_e'(bus_addr);
    assign sel_wr = bus_en &  bus_we & (idx == REG_PRESENCE);
    assign mbx_wr = bus_en &  bus_we & (idx == REG_MAILBOX);
    assign mbx_rd = bus_en & ~bus_we & (idx == REG_MAILBOX);

    mbx_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .sel_wr (sel_wr),
        .mbx_wr (mbx_wr),
        .mbx_rd (mbx_rd),
        .wdata  (bus_wdata),
        .regs_q (regs_q)
    );

    mbx_sel_decode u_dec (
        .sel_code    (regs_q.sel),
        .card_onehot (card_onehot)
    );

    mbx_card_rom u_rom (
        .card_onehot (card_onehot),
        .offset      (regs_q.cmd0[OFF_W-1:0]),
        .present_n   (present_n),
        .hit         (card_hit),
        .word        (card_word)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            unique case (idx)
                REG_PRESENCE: bus_rdata = {{(DATA_W-N_CARDS){1'b1}}, present_n};
                REG_STATUS:   bus_rdata = STATUS_WORD;
                REG_MAILBOX:  bus_rdata = (regs_q.armed && card_hit) ? card_word : EMPTY_WORD;
                REG_RESERVED: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mbx_eeprom_mailbox_chk.sv
module mbx_eeprom_mailbox_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_en,
    input logic        bus_we,
    input logic [1:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic        armed,
    input logic        ptr,
    input logic [15:0] sel,
    input logic [15:0] cmd1
);
    logic rd_mbx, wr_mbx;
    assign rd_mbx = bus_en && !bus_we && bus_addr == 2'd2;
    assign wr_mbx = bus_en &&  bus_we && bus_addr == 2'd2;

    AST_STATUS_FIXED: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && bus_addr == 2'd1) |-> bus_rdata == 16'h0004); // R8

    AST_PRESENCE_UPPER_ONES: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && bus_addr == 2'd0) |-> bus_rdata[15:3] == 13'h1FFF); // R1

    AST_ARM_ON_SECOND_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> ($past(wr_mbx) && $past(ptr))); // R3

    AST_PTR_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (wr_mbx && ptr) |=> !ptr && armed); // R3

    AST_READ_DISARMS: assert property (@(posedge clk) disable iff (rst)
        rd_mbx |=> !armed); // R5

    AST_IDLE_READ_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (rd_mbx && !armed) |-> bus_rdata == 16'hFFFF); // R6

    AST_SECOND_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        (wr_mbx && ptr) |=> cmd1 == $past(bus_wdata)); // R3

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!armed && !ptr && sel == 16'h0000 && cmd1 == 16'h0000)); // R9
endmodule

bind mbx_eeprom_mailbox mbx_eeprom_mailbox_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .armed     (regs_q.armed),
    .ptr       (regs_q.ptr),
    .sel       (regs_q.sel),
    .cmd1      (regs_q.cmd1)
);

// File: tb/mbx_eeprom_mailbox_bench.sv
module mbx_eeprom_mailbox_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [15:0] m_sel   = 16'h0000;
    logic        m_ptr   = 1'b0;
    logic        m_armed = 1'b0;
    logic [15:0] m_cmd0  = 16'h0000;

    always #4 clk = ~clk;

    mbx_eeprom_mailbox u_mbx_eeprom_mailbox (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] rom(input int c, input int a);
        int v;
        v = (a % 64) * 7 + c * 85 + 19;
        return v[7:0];
    endfunction

    function automatic int card_of(input logic [15:0] s);
        if (s == 16'h1700) return 0;
        if (s == 16'h1D00) return 1;
        if (s == 16'h3500) return 2;
        return -1;
    endfunction

    function automatic logic [15:0] exp_mbx();
        int c, a;
        c = card_of(m_sel);
        a = int'(m_cmd0[5:0]);
        if (!m_armed || c < 0 || c == 1) return 16'hFFFF;
        return {rom(c, a), rom(c, a + 1)};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
        if (a == 2'd0) m_sel = d;
        if (a == 2'd2) begin
            if (m_ptr) begin m_ptr = 1'b0; m_armed = 1'b1; end
            else begin m_cmd0 = d; m_ptr = 1'b1; end
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_en = 1'b0;
    endtask

    task automatic rd_mbx_check(input string req);
        logic [15:0] v, e;
        e = exp_mbx();
        rd(2'd2, v);
        check(req, v, e);
        m_armed = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_sel = 16'h0; m_ptr = 1'b0; m_armed = 1'b0; m_cmd0 = 16'h0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        logic [15:0] codes [6];
        int seed;
        codes = '{16'h1700, 16'h1D00, 16'h3500, 16'h1701, 16'h0000, 16'hFFFF};
        seed = 32'h5EED;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state seen at ports
        rd_mbx_check("R9 reset mailbox");
        rd(2'd0, v); check("R1 presence", v, 16'hFFFA);
        rd(2'd1, v); check("R8 status", v, 16'h0004);
        rd(2'd3, v); check("R8 reserved", v, 16'h0000);

        // R2 R4: card 0 at offset 5, upper bits of word 0 ignored
        wr(2'd0, 16'h1700);
        wr(2'd2, 16'h0185); wr(2'd2, 16'h0000);
        rd_mbx_check("R4 card0 off5");
        rd_mbx_check("R5 second read empty");

        // R3: one write does not arm
        wr(2'd2, 16'h0180);
        rd_mbx_check("R3 single write");
        wr(2'd2, 16'h0000);
        rd_mbx_check("R3 second write arms");

        // R4: wrap at offset 63 on card 2
        wr(2'd0, 16'h3500);
        wr(2'd2, 16'hFFBF); wr(2'd2, 16'h0000);
        rd_mbx_check("R4 wrap off63");

        // R7: empty card and unknown code
        wr(2'd0, 16'h1D00);
        wr(2'd2, 16'h0182); wr(2'd2, 16'h0000);
        rd_mbx_check("R7 empty card");
        wr(2'd0, 16'h3500);
        rd_mbx_check("R7 disarmed after empty read");
        wr(2'd0, 16'h3501);
        wr(2'd2, 16'h0182); wr(2'd2, 16'h0000);
        rd_mbx_check("R7 unknown code");

        // R8: writes to status have no effect
        wr(2'd0, 16'h1700);
        wr(2'd2, 16'h0190); wr(2'd1, 16'h1234); wr(2'd2, 16'h0000);
        rd(2'd1, v); check("R8 status after write", v, 16'h0004);
        rd_mbx_check("R8 status write leaves mailbox");

        // R9: reset clears pointer and select
        wr(2'd2, 16'h0181);
        do_reset();
        wr(2'd2, 16'h0183);
        rd_mbx_check("R9 pointer cleared");
        wr(2'd2, 16'h0000);
        rd_mbx_check("R9 select cleared");

        // R6 R1 R2 R4 R5: random mix
        for (int i = 0; i < 600; i++) begin
            int k;
            k = int'($urandom_range(0, 9));
            if (k < 2) wr(2'd0, codes[$urandom_range(0, 5)]);
            else if (k < 6) wr(2'd2, 16'(($urandom_range(0, 1) ? 16'h0180 : 16'h0000) | 16'($urandom_range(0, 1023))));
            else if (k < 9) rd_mbx_check("R4 R6 random mailbox");
            else begin rd(2'd0, v); check("R1 random presence", v, 16'hFFFA); end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule